// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Controller

This block watches sixteen general-purpose input lines, grouped as two ports of eight, and turns activity on them into interrupt requests. Each line has its own trigger settings. One bit picks level or edge sensing, and a second bit picks the active sense (low/falling or high/rising). Edge events are held in a per-line latch until software acknowledges them. Level requests track the pin for as long as the line is enabled.

Every port has a small bank of byte-wide registers on a simple memory-mapped bus: trigger select, polarity select, acknowledge, enable and status. The status bits of both ports are ORed into a single registered interrupt output, which feeds an upstream interrupt controller. Software reads the two status registers to find the source. The pins are asynchronous, so each one passes through a synchroniser before any detection takes place.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, so all lines are disabled, level-sensed and active-low. The interrupt output is low.
- R2: Port A registers sit at byte addresses 0x90 (trigger select), 0x94 (polarity), 0x98 (acknowledge), 0x9C (enable) and 0xA0 (status). Port B uses the same layout at 0xAC, 0xB0, 0xB4, 0xB8 and 0xBC. Trigger, polarity and enable read back the value last written. Acknowledge and unmapped addresses read zero. Read data appears one cycle after the read strobe.
- R3: A trigger bit of 0 selects level sensing. The status bit is then 1 exactly while the line is enabled and its synchronised pin equals its polarity bit (polarity 1 means high, polarity 0 means low). Writes to acknowledge do not change it.
- R4: A trigger bit of 1 selects edge sensing. A rising edge (polarity 1) or a falling edge (polarity 0) on an enabled line sets that line's status bit, and the bit stays set after the pin returns. The opposite edge sets nothing.
- R5: Writing a 1 to an acknowledge bit clears that line's latched edge. Bits written as 0 leave their latches unchanged.
- R6: While a line's enable bit is 0, its status reads 0 and no edge is latched. Clearing the enable bit discards any latched edge, so re-enabling after a trigger change or after edges seen while disabled shows no pending event.
- R7: The interrupt output is a registered OR of all sixteen status bits. It is high while any status bit of either port is set.
- R8: Line n is controlled by bit n mod 8 of port n div 8, and pin input bit n feeds that line only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | 16 | Asynchronous pin inputs, bit n is line n |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: two ports of eight lines, a two-stage synchroniser and the fixed register addresses. At that size it is practical to sweep all sixteen lines through all four trigger modes. For each combination the bench drives the active and the inactive transition, acknowledges with zero and non-zero masks, and toggles the enable bit. It also checks that the other port stays silent, which confirms the line-to-bit mapping and the combined output for every line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Register select within one port bank (word index from the bank base)
  typedef enum logic [2:0] {
    SEL_TRIG = 3'd0,
    SEL_POL  = 3'd1,
    SEL_ACK  = 3'd2,
    SEL_EN   = 3'd3,
    SEL_STAT = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_PORTS   = 2,
  parameter int BANK0_ADDR  = 144,
  parameter int BANK_STRIDE = 28
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_PORTS-1:0] port_hit,
  output reg_sel_e             sel
);
  localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'(16);

  always_comb begin
    port_hit = '0;
    sel      = SEL_TRIG;
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic [ADDR_W-1:0] off;
      off = addr - ADDR_W'(BANK0_ADDR + p*BANK_STRIDE);
      if (off <= LAST_OFF && off[1:0] == 2'b00) begin
        port_hit[p] = 1'b1;
        sel         = reg_sel_e'(off[4:2]);
      end
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pins,
  input  logic              we_trig,
  input  logic              we_pol,
  input  logic              we_ack,
  input  logic              we_en,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] trig_q,
  output logic [PORT_W-1:0] pol_q,
  output logic [PORT_W-1:0] en_q,
  output logic [PORT_W-1:0] status
);
  logic [PORT_W-1:0] pin_s, pin_prev, rise, fall, latch_q;

  gpio_irq_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pins), .q_sync(pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_prev <= '0;
      trig_q   <= '0;
      pol_q    <= '0;
      en_q     <= '0;
    end else begin
      pin_prev <= pin_s;
      if (we_trig) trig_q <= wdata;
      if (we_pol)  pol_q  <= wdata;
      if (we_en)   en_q   <= wdata;
    end
  end

  assign rise = pin_s & ~pin_prev;
  assign fall = ~pin_s & pin_prev;

  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_line
      logic edge_ev;
      assign edge_ev = pol_q[i] ? rise[i] : fall[i];

      // Held clear while disabled or level-sensed; a fresh edge wins over ack
      always_ff @(posedge clk) begin
        if (rst) latch_q[i] <= 1'b0;
        else if (!en_q[i] || !trig_q[i]) latch_q[i] <= 1'b0;
        else if (edge_ev) latch_q[i] <= 1'b1;
        else if (we_ack && wdata[i]) latch_q[i] <= 1'b0;
      end

      assign status[i] = en_q[i] &
                         (trig_q[i] ? latch_q[i] : ~(pin_s[i] ^ pol_q[i]));
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int PORT_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BANK0_ADDR  = 144,
  parameter int BANK_STRIDE = 28
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS*PORT_W-1:0] gpio_in,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [PORT_W-1:0]           bus_rdata,
  output logic                        irq_o
);
  localparam int LINES = NUM_PORTS * PORT_W;

  logic [NUM_PORTS-1:0] port_hit;
  reg_sel_e             sel;
  logic [PORT_W-1:0]    trig_a [NUM_PORTS];
  logic [PORT_W-1:0]    pol_a  [NUM_PORTS];
  logic [PORT_W-1:0]    en_a   [NUM_PORTS];
  logic [PORT_W-1:0]    stat_a [NUM_PORTS];
  logic [LINES-1:0]     status_all, en_all;

  gpio_irq_decode #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS),
    .BANK0_ADDR(BANK0_ADDR), .BANK_STRIDE(BANK_STRIDE)
  ) u_dec (
    .addr(bus_addr), .port_hit(port_hit), .sel(sel)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic wr_here;
      assign wr_here = bus_wr && port_hit[p];

      gpio_irq_port #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
        .clk     (clk),
        .rst     (rst),
        .pins    (gpio_in[p*PORT_W +: PORT_W]),
        .we_trig (wr_here && sel == SEL_TRIG),
        .we_pol  (wr_here && sel == SEL_POL),
        .we_ack  (wr_here && sel == SEL_ACK),
        .we_en   (wr_here && sel == SEL_EN),
        .wdata   (bus_wdata),
        .trig_q  (trig_a[p]),
        .pol_q   (pol_a[p]),
        .en_q    (en_a[p]),
        .status  (stat_a[p])
      );

      assign status_all[p*PORT_W +: PORT_W] = stat_a[p];
      assign en_all[p*PORT_W +: PORT_W]     = en_a[p];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= |status_all;
      if (bus_rd) begin
        bus_rdata <= '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (port_hit[p]) begin
            case (sel)
              SEL_TRIG: bus_rdata <= trig_a[p];
              SEL_POL:  bus_rdata <= pol_a[p];
              SEL_EN:   bus_rdata <= en_a[p];
              SEL_STAT: bus_rdata <= stat_a[p];
              default:  bus_rdata <= '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int LINES      = 16,
  parameter int PORT_W     = 8,
  parameter int ADDR_W     = 8,
  parameter int BANK0_ADDR = 144
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PORT_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic [LINES-1:0]  status_all,
  input logic [LINES-1:0]  en_all
);
  localparam logic [ADDR_W-1:0] ACK0 = ADDR_W'(BANK0_ADDR + 8);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && bus_rdata == '0));

  // R2
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ACK0) |=> bus_rdata == '0);

  // R6
  disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (status_all & ~en_all) == '0);

  // R7
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (status_all != '0) |=> irq_o);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(status_all) == '0) |-> !irq_o);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .LINES(NUM_PORTS*PORT_W), .PORT_W(PORT_W),
  .ADDR_W(ADDR_W), .BANK0_ADDR(BANK0_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_o(irq_o),
  .status_all(status_all), .en_all(en_all)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pins = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_o;
  int          total = 0, failed = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .gpio_in(pins), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state of every register in both banks
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 5; r++) begin
        rd(8'(8'h90 + p*8'h1C + r*4), v);
        chk(v, 0, "R1 reg reset");
      end
    chk(irq_o, 0, "R1 irq reset");

    // R2: readback, ack and unmapped reads
    wr(8'h90, 8'hA5); wr(8'h94, 8'h5A); wr(8'hB0, 8'h3C); wr(8'hAC, 8'hC3);
    rd(8'h90, v); chk(v, 8'hA5, "R2 trig A");
    rd(8'h94, v); chk(v, 8'h5A, "R2 pol A");
    rd(8'hAC, v); chk(v, 8'hC3, "R2 trig B");
    rd(8'hB0, v); chk(v, 8'h3C, "R2 pol B");
    wr(8'hB8, 8'h81);
    rd(8'hB8, v); chk(v, 8'h81, "R2 en B");
    rd(8'h9C, v); chk(v, 8'h00, "R2 en A untouched");
    rd(8'hB4, v); chk(v, 0, "R2 ack reads zero");
    rd(8'hA4, v); chk(v, 0, "R2 unmapped reads zero");
    wr(8'hB8, 0); wr(8'h90, 0); wr(8'h94, 0); wr(8'hAC, 0); wr(8'hB0, 0);

    // Sweep every line through every trigger mode (R3..R8)
    for (int line = 0; line < 16; line++) begin
      for (int mode = 0; mode < 4; mode++) begin
        int p, b;
        logic [7:0] base, other, m;
        logic edg, act;
        p = line >> 3; b = line & 7;
        base  = 8'(8'h90 + p*8'h1C);
        other = 8'(8'h90 + (1-p)*8'h1C);
        m = 8'(1 << b);
        edg = mode[1]; act = mode[0];

        pins = act ? 16'h0000 : 16'hFFFF;
        settle();
        wr(8'(base+4), act ? m : 8'h00);
        wr(base, edg ? m : 8'h00);
        wr(8'(base+12), m);
        settle();
        rd(8'(base+16), v); chk(v, 0, "R3/R4 idle status");
        chk(irq_o, 0, "R7 idle irq");

        pins[line] = act;
        settle();
        rd(8'(base+16), v); chk(v, m, "R3/R4/R8 active status");
        rd(8'(other+16), v); chk(v, 0, "R8 other port silent");
        chk(irq_o, 1, "R7 irq raised");

        if (!edg) begin
          wr(8'(base+8), m);
          rd(8'(base+16), v); chk(v, m, "R3 ack ignored in level");
          pins[line] = ~act;
          settle();
          rd(8'(base+16), v); chk(v, 0, "R3 level follows pin");
          chk(irq_o, 0, "R7 irq drops");
        end else begin
          pins[line] = ~act;
          settle();
          rd(8'(base+16), v); chk(v, m, "R4 edge held");
          wr(8'(base+8), ~m);
          rd(8'(base+16), v); chk(v, m, "R5 ack zero bit no effect");
          wr(8'(base+12), 0); wr(8'(base+12), m);
          settle();
          rd(8'(base+16), v); chk(v, 0, "R6 disable discards latch");
          pins[line] = act;
          settle();
          pins[line] = ~act;
          settle();
          rd(8'(base+16), v); chk(v, m, "R4 relatched");
          wr(8'(base+8), m);
          @(negedge clk); @(negedge clk);
          chk(irq_o, 0, "R5 irq after ack");
          rd(8'(base+16), v); chk(v, 0, "R5 ack clears");
          wr(8'(base+12), 0);
          wr(8'(base+4), act ? 8'h00 : m);
          pins[line] = act;
          settle();
          wr(8'(base+4), act ? m : 8'h00);
          wr(8'(base+12), m);
          settle();
          rd(8'(base+16), v); chk(v, 0, "R6 no spurious after retype");
          pins[line] = ~act;
          settle();
          rd(8'(base+16), v); chk(v, 0, "R4 opposite edge ignored");
        end
        wr(8'(base+12), 0); wr(base, 0); wr(8'(base+4), 0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule